// File: doc/BRIEF.md
# JTAG Debug-Port Transfer Engine

This block performs a single read or write of a debug-port register over a JTAG scan chain. The target device is chosen by its position in the chain, and every other device in the chain is assumed to hold its one-bit bypass register. A controller supplies the following on a one-cycle `start` pulse:

- the direction flag and two address bits;
- the 32-bit write value;
- the target position and the chain length;
- an idle-clock count;
- an acknowledge-check enable.

The engine then drives TCK, TMS and TDI itself and samples TDO. When the transfer ends it pulses `done` and presents the acknowledge it captured and, for reads, the 32-bit read value.

Each TCK period has two phases. TCK is low for `HALF` system clocks, with TMS and TDI already at their new values. TCK is then high for `HALF` system clocks, and TDO is sampled as TCK rises.

A scan walks the following states:

1. Run-Test/Idle.
2. Select-DR, Capture-DR and Shift-DR, passing the bypass bits that sit ahead of the target.
3. The three request bits, during which the acknowledge is collected.
4. The data bits, followed by the bypass bits that sit behind the target.
5. Update-DR, then back to Run-Test/Idle.
6. The optional idle clocks.

An abort write uses this same path: a write with both address bits and the direction flag at zero, and with checking off.

Top module: `jtag_dp_xfer`

## Requirements
- R1: After reset, `tck`, `tms` and `tdi` are high and `done` is low.
- R2: A scan begins with one TCK period with TMS high. It is followed by `2 + dev_idx` periods with TMS low. TDI is high throughout these periods.
- R3: The next three periods carry TMS low, with TDI equal to `req_rnw`, then `req_addr[0]`, then `req_addr[1]`.
- R4: The TDO bits sampled in those three periods are stored as `ack[1]`, `ack[0]` and `ack[2]`, in that order of sampling. They then stay unchanged until the next start.
- R5: The OK acknowledge is `3'b010`. When `ack_chk` is 1 and the acknowledge is not OK, one period with TMS high follows and the data phase is skipped.
- R6: The data phase moves 32 bits LSB first. A write drives `wdata[k]` on TDI. A read keeps TDI high and collects TDO into `rdata`.
- R7: The trailing bypass count is `n = dev_cnt - dev_idx - 1`. The data phase lasts `32 + n` periods and has TMS high only in its last period. Periods after the 32 data bits carry TDI high.
- R8: Every scan ends with one period with TMS high and then one with TMS low, both with TDI high.
- R9: With `ack_chk` at 1, exactly `idle_cnt` further periods follow with TMS low and TDI high. With `ack_chk` at 0, no further periods follow.
- R10: A start with `dev_idx >= dev_cnt` gives `done` and `err` in the next cycle and produces no TCK pulse.
- R11: `done` is a one-cycle pulse raised after the final TCK high phase. At that point `ack` holds the captured acknowledge and `rdata` holds the read value.
- R12: Each TCK low phase lasts `HALF` clocks. TMS and TDI hold steady through it.
- R13: A `start` pulse while a transfer is in progress is ignored. Input changes during a transfer do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled only when idle) |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits A2 (bit 0) and A3 (bit 1) |
| wdata | input | 32 | Write value |
| dev_idx | input | 8 | Chain position of the target |
| dev_cnt | input | 8 | Number of devices in the chain |
| idle_cnt | input | 16 | Idle clocks added after the exit |
| ack_chk | input | 1 | Enable acknowledge check and idle clocks |
| tdo | input | 1 | Serial data from the chain |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data to the chain |
| ack | output | 3 | Captured acknowledge |
| rdata | output | 32 | Read value |
| done | output | 1 | Transfer finished (one cycle) |
| err | output | 1 | Index out of range on the last start |

## Verification
The assertions assume three things about the inputs:

- TDO changes only while TCK is low.
- `start` is a single-cycle pulse.
- The request fields are only meaningful in the cycle `start` is high.

The bench models the chain as a target that updates TDO on each falling TCK edge. It drives the request inputs and `start` on falling system-clock edges, so none of them moves at the instant the engine samples it. The one deliberate departure is a stray `start` pulse with altered fields in the middle of a transfer. The expected TMS/TDI stream must absorb that pulse unchanged.

// File: rtl/jdx_pkg.sv
package jdx_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HEAD,
        S_PRE,
        S_REQ,
        S_CHK,
        S_DATA,
        S_EXIT,
        S_RTI,
        S_FIN
    } seq_st_e;

    typedef enum logic [2:0] {
        T_NONE,
        T_ACK0,
        T_ACK1,
        T_ACK2,
        T_RD
    } cap_tag_e;

    localparam logic [2:0] ACK_OK = 3'b010;

endpackage

// File: rtl/jdx_bitclk.sv
module jdx_bitclk #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic tms_in,
    input  logic tdi_in,
    input  logic tdo,
    output logic ready,
    output logic bit_end,
    output logic smp,
    output logic tck,
    output logic tms,
    output logic tdi
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic          busy;
        logic          hi;
        logic [HW-1:0] cnt;
        logic          tck;
        logic          tms;
        logic          tdi;
        logic          smp;
    } bc_t;

    bc_t q, d;

    always_comb begin
        d       = q;
        bit_end = q.busy && q.hi && (q.cnt == '0);
        ready   = !q.busy || bit_end;
        if (q.busy) begin
            if (q.cnt != '0) begin
                d.cnt = q.cnt - HW'(1);
            end else if (!q.hi) begin
                d.hi  = 1'b1;
                d.tck = 1'b1;
                d.smp = tdo;
                d.cnt = HW'(HALF - 1);
            end else begin
                d.busy = 1'b0;
            end
        end
        if (issue && ready) begin
            d.busy = 1'b1;
            d.hi   = 1'b0;
            d.tck  = 1'b0;
            d.tms  = tms_in;
            d.tdi  = tdi_in;
            d.cnt  = HW'(HALF - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, hi: 1'b0, cnt: '0, tck: 1'b1, tms: 1'b1, tdi: 1'b1, smp: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign smp = q.smp;
    assign tck = q.tck;
    assign tms = q.tms;
    assign tdi = q.tdi;

    assert_low_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.tck && $past(!q.tck)) |-> ($stable(q.tms) && $stable(q.tdi)));

    assert_low_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !q.tck |-> q.busy);

endmodule

// File: rtl/jdx_seq.sv
module jdx_seq
    import jdx_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int IDLE_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_rnw,
    input  logic [1:0]        req_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  dev_idx,
    input  logic [IDX_W-1:0]  dev_cnt,
    input  logic [IDLE_W-1:0] idle_cnt,
    input  logic              ack_chk,
    input  logic              ready,
    input  logic              bit_end,
    input  logic              smp,
    output logic              issue,
    output logic              b_tms,
    output logic              b_tdi,
    output logic [2:0]        ack,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              err,
    output seq_st_e           st
);
    localparam int CW_A  = IDX_W + $clog2(DATA_W) + 1;
    localparam int CNT_W = (IDLE_W > CW_A) ? IDLE_W : CW_A;

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  n;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  trail;
        logic [IDLE_W-1:0] idle;
        logic              rnw;
        logic [1:0]        addr;
        logic [DATA_W-1:0] wsh;
        logic              chk;
        logic [2:0]        ack;
        logic [DATA_W-1:0] rdata;
        cap_tag_e          tag;
        logic              done;
        logic              err;
    } sq_t;

    sq_t q, d;
    cap_tag_e tag_new;
    logic     last;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        issue   = 1'b0;
        b_tms   = 1'b0;
        b_tdi   = 1'b1;
        tag_new = T_NONE;
        last    = 1'b0;

        if (bit_end) begin
            case (q.tag)
                T_ACK0:  d.ack[1] = smp;
                T_ACK1:  d.ack[0] = smp;
                T_ACK2:  d.ack[2] = smp;
                T_RD:    d.rdata  = {smp, q.rdata[DATA_W-1:1]};
                default: ;
            endcase
        end

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    if (dev_idx >= dev_cnt) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.err   = 1'b0;
                        d.st    = S_HEAD;
                        d.idx   = dev_idx;
                        d.trail = dev_cnt - dev_idx - IDX_W'(1);
                        d.idle  = idle_cnt;
                        d.rnw   = req_rnw;
                        d.addr  = req_addr;
                        d.wsh   = wdata;
                        d.chk   = ack_chk;
                        d.ack   = '0;
                    end
                end
            end
            S_HEAD: begin
                if (ready) begin
                    issue = 1'b1;
                    b_tms = 1'b1;
                    d.st  = S_PRE;
                    d.n   = '0;
                end
            end
            S_PRE: begin
                if (ready) begin
                    issue = 1'b1;
                    d.n   = q.n + CNT_W'(1);
                    if (q.n == CNT_W'(q.idx) + CNT_W'(1)) begin
                        d.st = S_REQ;
                        d.n  = '0;
                    end
                end
            end
            S_REQ: begin
                if (ready) begin
                    issue = 1'b1;
                    d.n   = q.n + CNT_W'(1);
                    case (q.n[1:0])
                        2'd0:    begin b_tdi = q.rnw;     tag_new = T_ACK0; end
                        2'd1:    begin b_tdi = q.addr[0]; tag_new = T_ACK1; end
                        default: begin b_tdi = q.addr[1]; tag_new = T_ACK2; end
                    endcase
                    if (q.n[1:0] == 2'd2) begin
                        d.st = S_CHK;
                        d.n  = '0;
                    end
                end
            end
            S_CHK: begin
                if (ready && !bit_end) begin
                    d.n = '0;
                    if (q.chk && (q.ack != ACK_OK)) begin
                        issue = 1'b1;
                        b_tms = 1'b1;
                        d.st  = S_EXIT;
                    end else begin
                        d.st = S_DATA;
                    end
                end
            end
            S_DATA: begin
                if (ready) begin
                    issue = 1'b1;
                    last  = (q.n == CNT_W'(DATA_W - 1) + CNT_W'(q.trail));
                    b_tms = last;
                    if (q.n < CNT_W'(DATA_W)) begin
                        if (q.rnw) begin
                            tag_new = T_RD;
                        end else begin
                            b_tdi = q.wsh[0];
                        end
                        d.wsh = q.wsh >> 1;
                    end
                    d.n = q.n + CNT_W'(1);
                    if (last) begin
                        d.st = S_EXIT;
                        d.n  = '0;
                    end
                end
            end
            S_EXIT: begin
                if (ready) begin
                    issue = 1'b1;
                    b_tms = (q.n == '0);
                    d.n   = q.n + CNT_W'(1);
                    if (q.n != '0) begin
                        d.n  = '0;
                        d.st = (q.chk && (q.idle != '0)) ? S_RTI : S_FIN;
                    end
                end
            end
            S_RTI: begin
                if (ready) begin
                    issue = 1'b1;
                    d.n   = q.n + CNT_W'(1);
                    if (q.n == CNT_W'(q.idle) - CNT_W'(1)) begin
                        d.st = S_FIN;
                        d.n  = '0;
                    end
                end
            end
            S_FIN: begin
                if (ready && !bit_end) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (issue) begin
            d.tag = tag_new;
        end else if (bit_end) begin
            d.tag = T_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, n: '0, idx: '0, trail: '0, idle: '0, rnw: 1'b0, addr: '0,
                   wsh: '0, chk: 1'b0, ack: '0, rdata: '0, tag: T_NONE, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ack   = q.ack;
    assign rdata = q.rdata;
    assign done  = q.done;
    assign err   = q.err;
    assign st    = q.st;

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    assert_err_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.err) |-> $past(q.st == S_IDLE));

    assert_ack_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DATA || q.st == S_EXIT || q.st == S_RTI) |=> $stable(q.ack));

endmodule

// File: rtl/jtag_dp_xfer.sv
module jtag_dp_xfer
    import jdx_pkg::*;
#(
    parameter int HALF   = 2,
    parameter int IDX_W  = 8,
    parameter int IDLE_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_rnw,
    input  logic [1:0]        req_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  dev_idx,
    input  logic [IDX_W-1:0]  dev_cnt,
    input  logic [IDLE_W-1:0] idle_cnt,
    input  logic              ack_chk,
    input  logic              tdo,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic [2:0]        ack,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              err
);
    logic    issue, b_tms, b_tdi, ready, bit_end, smp;
    seq_st_e st;

    jdx_seq #(
        .IDX_W (IDX_W),
        .IDLE_W(IDLE_W),
        .DATA_W(DATA_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .req_rnw (req_rnw),
        .req_addr(req_addr),
        .wdata   (wdata),
        .dev_idx (dev_idx),
        .dev_cnt (dev_cnt),
        .idle_cnt(idle_cnt),
        .ack_chk (ack_chk),
        .ready   (ready),
        .bit_end (bit_end),
        .smp     (smp),
        .issue   (issue),
        .b_tms   (b_tms),
        .b_tdi   (b_tdi),
        .ack     (ack),
        .rdata   (rdata),
        .done    (done),
        .err     (err),
        .st      (st)
    );

    jdx_bitclk #(
        .HALF(HALF)
    ) u_bitclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (issue),
        .tms_in (b_tms),
        .tdi_in (b_tdi),
        .tdo    (tdo),
        .ready  (ready),
        .bit_end(bit_end),
        .smp    (smp),
        .tck    (tck),
        .tms    (tms),
        .tdi    (tdi)
    );

    assert_idle_tck_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> tck);

endmodule

// File: tb/jtag_dp_xfer_tb.sv
module jtag_dp_xfer_tb;
    localparam int HALF = 2;
    localparam int CLKP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_rnw = 1'b0;
    logic [1:0]  req_addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  dev_idx = '0;
    logic [7:0]  dev_cnt = 8'd1;
    logic [15:0] idle_cnt = '0;
    logic        ack_chk = 1'b0;
    logic        tdo = 1'b0;
    logic        tck, tms, tdi, done, err;
    logic [2:0]  ack;
    logic [31:0] rdata;

    int    n_chk = 0;
    int    n_err = 0;
    bit    armed = 1'b0;
    bit    exp_tms[$];
    bit    exp_tdi[$];
    string exp_req[$];
    bit    tdo_q[$];
    time   t_fall;

    always #(CLKP/2) clk = ~clk;

    jtag_dp_xfer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_rnw(req_rnw), .req_addr(req_addr),
        .wdata(wdata), .dev_idx(dev_idx), .dev_cnt(dev_cnt), .idle_cnt(idle_cnt),
        .ack_chk(ack_chk), .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi), .ack(ack),
        .rdata(rdata), .done(done), .err(err)
    );

    task automatic check(string r, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // target model: next TDO bit presented after each falling TCK
    initial forever begin
        @(negedge tck);
        t_fall = $time;
        if (armed && tdo_q.size() > 0) tdo = tdo_q.pop_front();
        else tdo = 1'b0;
    end

    // reference stream compared at every rising TCK
    initial forever begin
        @(posedge tck);
        #1;
        if (armed) begin
            check("R12", "low phase length", longint'($time - 1 - t_fall), longint'(HALF*CLKP));
            if (exp_tms.size() == 0) begin
                check("R13", "unexpected TCK pulse", 1, 0);
            end else begin
                automatic string r = exp_req.pop_front();
                check(r, "tms", tms, exp_tms.pop_front());
                check(r, "tdi", tdi, exp_tdi.pop_front());
            end
        end
    end

    initial begin
        #(CLKP * 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic push(bit m, bit i, string r, bit o);
        exp_tms.push_back(m);
        exp_tdi.push_back(i);
        exp_req.push_back(r);
        tdo_q.push_back(o);
    endtask

    task automatic xfer(bit rnw, bit [1:0] addr, bit [31:0] wd, int idx, int cnt, int idle,
                        bit chk, bit [2:0] a, bit [31:0] rd, bit poke);
        automatic int  n   = cnt - idx - 1;
        automatic bit  bad = chk && (a != 3'b010);
        automatic int  guard = 0;
        push(1, 1, "R2", 1);
        for (int k = 0; k < 2 + idx; k++) push(0, 1, "R2", 1);
        push(0, rnw,     "R3", a[1]);
        push(0, addr[0], "R3", a[0]);
        push(0, addr[1], "R3", a[2]);
        if (bad) begin
            push(1, 1, "R5", 0);
        end else begin
            for (int k = 0; k < 32 + n; k++) begin
                automatic bit m = (k == 31 + n);
                if (k < 32) push(m, rnw ? 1'b1 : wd[k], "R6", rnw ? rd[k] : 1'b0);
                else        push(m, 1, "R7", 0);
            end
        end
        push(1, 1, "R8", 0);
        push(0, 1, "R8", 0);
        if (chk) for (int k = 0; k < idle; k++) push(0, 1, "R9", 0);

        @(negedge clk);
        req_rnw = rnw; req_addr = addr; wdata = wd; dev_idx = 8'(idx); dev_cnt = 8'(cnt);
        idle_cnt = 16'(idle); ack_chk = chk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (poke && guard == 30) begin
                req_rnw = ~rnw; dev_idx = 0; dev_cnt = 1; wdata = ~wd; idle_cnt = 0;
                ack_chk = ~chk; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check("R11", "done seen", done, 1);
        check("R10", "err clear", err, 0);
        check("R4", "ack", ack, a);
        if (rnw && !bad) check("R6", "rdata", rdata, rd);
        check("R9", "all expected TCK periods seen", exp_tms.size(), 0);
        check("R11", "tck high at done", tck, 1);
        @(negedge clk);
        check("R11", "done one cycle", done, 0);
        repeat (6) @(negedge clk);
        check("R9", "no TCK after done", exp_tms.size(), 0);
        tdo_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "tck at reset", tck, 1);
        check("R1", "tms at reset", tms, 1);
        check("R1", "tdi at reset", tdi, 1);
        check("R1", "done at reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1'b1;

        // read, target alone in chain, ack OK, idle clocks
        xfer(1, 2'b10, 32'h0, 0, 1, 3, 1, 3'b010, 32'hDEAD_BEEF, 0);
        // write, one device behind target
        xfer(0, 2'b01, 32'hA5C3_0F81, 1, 3, 2, 1, 3'b010, 32'h0, 0);
        // read, two devices behind, checking off so idle ignored
        xfer(1, 2'b11, 32'h0, 2, 5, 7, 0, 3'b010, 32'h1234_5679, 0);
        // bad ack (WAIT) with checking: short path plus idle
        xfer(1, 2'b00, 32'h0, 1, 2, 2, 1, 3'b001, 32'h0, 0);
        // FAULT pattern checks ack[2] position, short path
        xfer(0, 2'b10, 32'hFFFF_0000, 0, 2, 0, 1, 3'b100, 32'h0, 0);
        // bad ack with checking off: full data phase still runs
        xfer(1, 2'b01, 32'h0, 0, 1, 4, 0, 3'b001, 32'h8000_0001, 0);
        // abort-style write: all request bits zero, no check
        xfer(0, 2'b00, 32'h0000_001E, 0, 1, 5, 0, 3'b000, 32'h0, 0);
        // start pulse mid-transfer must be ignored (R13)
        xfer(0, 2'b11, 32'h7E00_00F1, 1, 4, 1, 1, 3'b010, 32'h0, 1);

        // index out of range (R10)
        begin
            automatic int edges_before = exp_tms.size();
            @(negedge clk);
            dev_idx = 8'd3; dev_cnt = 8'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R10", "done on bad index", done, 1);
            check("R10", "err on bad index", err, 1);
            repeat (10) @(negedge clk);
            check("R10", "tck stays high", tck, 1);
            check("R10", "no expected stream", exp_tms.size(), edges_before);
        end

        summary();
    end
endmodule